// File: doc/BRIEF.md
# Processor Status Flags and Stack Pointer

This block holds the condition flags and the stack pointer of a small 8-bit microcontroller core. It presents both on the core's internal I/O register bus. Writes from that bus, and reads through a combinational read port, use a 6-bit I/O address. The ALU computes its result flags elsewhere and hands them in as a value word with a per-flag update mask. The interrupt controller signals interrupt entry and return-from-interrupt. The bit-copy instructions use the T flag as a one-bit scratch location: one copies a chosen bit of a general register into T, and the other writes T back into a chosen bit.

The stack pointer is narrower than 16 bits. The parameter `SP_W` sets its width to match the size of data memory, for example 9 or 10. Bits above that width ignore writes and read as zero. Push and pop requests move the pointer. The block also supplies the data-memory address to use for the current stack access. The status word is never saved or restored automatically: only the global interrupt enable changes on interrupt entry and return.

Top module: `cpu_state_regs`

## Requirements
- R1: After reset, the status word, the stack pointer, `gie` and `t_bit` are all 0, so interrupts are globally disabled.
- R2: The status word is read and written at I/O address 0x3F. Its bit layout is 7=I, 6=T, 5=H, 4=S, 3=V, 2=N, 1=Z, 0=C. `gie` equals bit 7.
- R3: S always equals N XOR V of the stored N and V. A value written into bit 4 is ignored, and S is recomputed whenever N or V changes.
- R4: `irq_enter` clears I on the next edge. It wins over `irq_return` and over an I/O write of the status word in the same cycle.
- R5: `irq_return` without `irq_enter` sets I on the next edge.
- R6: `alu_we`/`alu_val` bit 4=H, 3=V, 2=N, 1=Z, 0=C. Only the masked flags take the new values. An I/O write of the status word in the same cycle wins over the ALU update.
- R7: `bst_req` loads T with bit `bst_sel` of `bst_src`, unless an I/O write of the status word occurs in the same cycle. `bld_result` is `bld_dst` with bit `bld_sel` replaced by T.
- R8: The stack pointer low byte is at I/O address 0x3D and the high byte at 0x3E. High-byte bits at positions `SP_W`-8 and above ignore writes and read as 0.
- R9: On push, `stack_addr` equals the pointer and the pointer then decrements. On pop, `stack_addr` equals the pointer plus one and the pointer then increments. Both wrap within `SP_W` bits.
- R10: An I/O write of either stack-pointer byte wins over push and pop. Push and pop together leave the pointer unchanged.
- R11: Interrupt entry and return alter no status bit other than I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 6 | I/O register address for read and write |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Read data for `io_addr` (combinational) |
| alu_we | input | 5 | Per-flag update mask {H,V,N,Z,C} |
| alu_val | input | 5 | New flag values {H,V,N,Z,C} |
| irq_enter | input | 1 | Interrupt taken this cycle |
| irq_return | input | 1 | Return-from-interrupt this cycle |
| bst_req | input | 1 | Copy a register bit into T |
| bst_src | input | 8 | Source register value for the copy |
| bst_sel | input | 3 | Bit index within `bst_src` |
| bld_dst | input | 8 | Destination register value for a T write-back |
| bld_sel | input | 3 | Bit index within `bld_dst` |
| bld_result | output | 8 | `bld_dst` with the selected bit replaced by T |
| sp_push | input | 1 | Stack push this cycle |
| sp_pop | input | 1 | Stack pop this cycle |
| stack_addr | output | SP_W | Data-memory address of the current stack access |
| status_word | output | 8 | Current status flags |
| gie | output | 1 | Global interrupt enable |
| t_bit | output | 1 | Current T flag |
| sp_value | output | SP_W | Current stack pointer |

## Verification
A wrong flag shows up one edge after the event that caused it, both in `status_word` and in a read of 0x3F. A stale S, an I left set after interrupt entry, or a T that took the wrong bit is therefore visible on the very next sample. Stack-pointer errors appear the same way. A wrong step or a missing wrap changes `sp_value` right away. A leak into the unused high bits changes the 0x3E read right away. A wrong address offset shows up combinationally on `stack_addr` before the edge.

// File: rtl/cpu_state_pkg.sv
package cpu_state_pkg;
    localparam int IO_AW = 6;
    localparam logic [IO_AW-1:0] ADDR_STATUS = 6'h3F;
    localparam logic [IO_AW-1:0] ADDR_SP_HI  = 6'h3E;
    localparam logic [IO_AW-1:0] ADDR_SP_LO  = 6'h3D;

    // status word bit positions (decoded by the core)
    localparam int POS_I = 7;
    localparam int POS_T = 6;
    localparam int POS_H = 5;
    localparam int POS_S = 4;
    localparam int POS_V = 3;
    localparam int POS_N = 2;
    localparam int POS_Z = 1;
    localparam int POS_C = 0;

    // ALU mask order {H,V,N,Z,C}
    localparam int ALU_FW = 5;

    function automatic int alu_to_pos(input int k);
        case (k)
            4:       return POS_H;
            3:       return POS_V;
            2:       return POS_N;
            1:       return POS_Z;
            default: return POS_C;
        endcase
    endfunction
endpackage

// File: rtl/flag_reg.sv
module flag_reg
    import cpu_state_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    input  logic [ALU_FW-1:0] alu_we,
    input  logic [ALU_FW-1:0] alu_val,
    input  logic              irq_enter,
    input  logic              irq_return,
    input  logic              bst_req,
    input  logic              bst_bit,
    output logic [7:0]        flags
);
    logic [7:0] flags_q;
    logic [7:0] after_alu;
    logic [7:0] flags_nx;

    // ALU-driven flags, one lane per masked flag
    always_comb begin
        after_alu = flags_q;
        for (int k = 0; k < ALU_FW; k++) begin
            if (alu_we[k]) after_alu[alu_to_pos(k)] = alu_val[k];
        end
        if (bst_req) after_alu[POS_T] = bst_bit;
    end

    always_comb begin
        flags_nx = wr_en ? wdata : after_alu;
        if (irq_enter)       flags_nx[POS_I] = 1'b0;
        else if (irq_return) flags_nx[POS_I] = 1'b1;
        flags_nx[POS_S] = flags_nx[POS_N] ^ flags_nx[POS_V];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_nx;
    end

    assign flags = flags_q;

    // R3
    property s_equation_p;
        @(posedge clk) disable iff (!rst_n)
        flags_q[POS_S] == (flags_q[POS_N] ^ flags_q[POS_V]);
    endproperty
    s_equation_chk: assert property (s_equation_p);

    // R4
    property irq_clear_p;
        @(posedge clk) disable iff (!rst_n)
        irq_enter |=> !flags_q[POS_I];
    endproperty
    irq_clear_chk: assert property (irq_clear_p);

    // R5
    property irq_set_p;
        @(posedge clk) disable iff (!rst_n)
        (irq_return && !irq_enter) |=> flags_q[POS_I];
    endproperty
    irq_set_chk: assert property (irq_set_p);

    // R11
    property irq_keep_p;
        @(posedge clk) disable iff (!rst_n)
        ((irq_enter || irq_return) && !wr_en && alu_we == '0 && !bst_req)
            |=> flags_q[6:0] == $past(flags_q[6:0]);
    endproperty
    irq_keep_chk: assert property (irq_keep_p);

    // R7
    property t_store_p;
        @(posedge clk) disable iff (!rst_n)
        (bst_req && !wr_en) |=> flags_q[POS_T] == $past(bst_bit);
    endproperty
    t_store_chk: assert property (t_store_p);

    // R6
    property io_wins_p;
        @(posedge clk) disable iff (!rst_n)
        wr_en |=> (flags_q[6:5] == $past(wdata[6:5])) &&
                  (flags_q[3:0] == $past(wdata[3:0]));
    endproperty
    io_wins_chk: assert property (io_wins_p);
endmodule

// File: rtl/stack_ptr.sv
module stack_ptr #(
    parameter int W = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [7:0]    wdata_lo,
    input  logic [W-9:0]  wdata_hi,
    input  logic          push,
    input  logic          pop,
    output logic [W-1:0]  sp,
    output logic [W-1:0]  stack_addr
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] sp_q;
    logic [W-1:0] sp_inc;
    logic [W-1:0] sp_dec;

    assign sp_inc = sp_q + ONE;
    assign sp_dec = sp_q - ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) sp_q[7:0]   <= wdata_lo;
            if (wr_hi) sp_q[W-1:8] <= wdata_hi;
        end else if (push && !pop) begin
            sp_q <= sp_dec;
        end else if (pop && !push) begin
            sp_q <= sp_inc;
        end
    end

    assign sp         = sp_q;
    assign stack_addr = pop ? sp_inc : sp_q;

    // R9
    property push_dec_p;
        @(posedge clk) disable iff (!rst_n)
        (push && !pop && !wr_lo && !wr_hi) |=> sp_q == $past(sp_q) - ONE;
    endproperty
    push_dec_chk: assert property (push_dec_p);

    // R9
    property pop_inc_p;
        @(posedge clk) disable iff (!rst_n)
        (pop && !push && !wr_lo && !wr_hi) |=> sp_q == $past(sp_q) + ONE;
    endproperty
    pop_inc_chk: assert property (pop_inc_p);

    // R10
    property both_hold_p;
        @(posedge clk) disable iff (!rst_n)
        (push && pop && !wr_lo && !wr_hi) |=> $stable(sp_q);
    endproperty
    both_hold_chk: assert property (both_hold_p);
endmodule

// File: rtl/cpu_state_regs.sv
module cpu_state_regs
    import cpu_state_pkg::*;
#(
    parameter int SP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [ALU_FW-1:0] alu_we,
    input  logic [ALU_FW-1:0] alu_val,
    input  logic              irq_enter,
    input  logic              irq_return,
    input  logic              bst_req,
    input  logic [7:0]        bst_src,
    input  logic [2:0]        bst_sel,
    input  logic [7:0]        bld_dst,
    input  logic [2:0]        bld_sel,
    output logic [7:0]        bld_result,
    input  logic              sp_push,
    input  logic              sp_pop,
    output logic [SP_W-1:0]   stack_addr,
    output logic [7:0]        status_word,
    output logic              gie,
    output logic              t_bit,
    output logic [SP_W-1:0]   sp_value
);
    localparam int HI_W = SP_W - 8;

    logic        wr_status;
    logic        wr_sp_lo;
    logic        wr_sp_hi;
    logic [7:0]  flags;
    logic [15:0] sp_wide;

    assign wr_status = io_wr && (io_addr == ADDR_STATUS);
    assign wr_sp_lo  = io_wr && (io_addr == ADDR_SP_LO);
    assign wr_sp_hi  = io_wr && (io_addr == ADDR_SP_HI);

    flag_reg u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_status),
        .wdata      (io_wdata),
        .alu_we     (alu_we),
        .alu_val    (alu_val),
        .irq_enter  (irq_enter),
        .irq_return (irq_return),
        .bst_req    (bst_req),
        .bst_bit    (bst_src[bst_sel]),
        .flags      (flags)
    );

    stack_ptr #(.W(SP_W)) u_sp (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_lo      (wr_sp_lo),
        .wr_hi      (wr_sp_hi),
        .wdata_lo   (io_wdata),
        .wdata_hi   (io_wdata[HI_W-1:0]),
        .push       (sp_push),
        .pop        (sp_pop),
        .sp         (sp_value),
        .stack_addr (stack_addr)
    );

    assign status_word = flags;
    assign gie         = flags[POS_I];
    assign t_bit       = flags[POS_T];
    assign sp_wide     = 16'(sp_value);

    always_comb begin
        bld_result          = bld_dst;
        bld_result[bld_sel] = flags[POS_T];
    end

    always_comb begin
        case (io_addr)
            ADDR_STATUS: io_rdata = flags;
            ADDR_SP_HI:  io_rdata = sp_wide[15:8];
            ADDR_SP_LO:  io_rdata = sp_wide[7:0];
            default:     io_rdata = '0;
        endcase
    end

    // R8
    property sp_hi_zero_p;
        @(posedge clk) disable iff (!rst_n)
        (io_addr == ADDR_SP_HI) |-> ((io_rdata >> HI_W) == 8'd0);
    endproperty
    sp_hi_zero_chk: assert property (sp_hi_zero_p);

    // R10
    property sp_io_wins_p;
        @(posedge clk) disable iff (!rst_n)
        wr_sp_lo |=> sp_value[7:0] == $past(io_wdata);
    endproperty
    sp_io_wins_chk: assert property (sp_io_wins_p);
endmodule

// File: tb/test_cpu_state_regs.sv
module test_cpu_state_regs;
    localparam int SP_W = 10;
    localparam int SP_MASK = (1 << SP_W) - 1;

    logic            clk = 0;
    logic            rst_n = 0;
    logic [5:0]      io_addr = 0;
    logic            io_wr = 0;
    logic [7:0]      io_wdata = 0;
    logic [7:0]      io_rdata;
    logic [4:0]      alu_we = 0, alu_val = 0;
    logic            irq_enter = 0, irq_return = 0;
    logic            bst_req = 0;
    logic [7:0]      bst_src = 0;
    logic [2:0]      bst_sel = 0;
    logic [7:0]      bld_dst = 0;
    logic [2:0]      bld_sel = 0;
    logic [7:0]      bld_result;
    logic            sp_push = 0, sp_pop = 0;
    logic [SP_W-1:0] stack_addr;
    logic [7:0]      status_word;
    logic            gie, t_bit;
    logic [SP_W-1:0] sp_value;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cpu_state_regs #(.SP_W(SP_W)) i_cpu_state_regs (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .alu_we(alu_we),
        .alu_val(alu_val), .irq_enter(irq_enter), .irq_return(irq_return),
        .bst_req(bst_req), .bst_src(bst_src), .bst_sel(bst_sel),
        .bld_dst(bld_dst), .bld_sel(bld_sel), .bld_result(bld_result),
        .sp_push(sp_push), .sp_pop(sp_pop), .stack_addr(stack_addr),
        .status_word(status_word), .gie(gie), .t_bit(t_bit),
        .sp_value(sp_value)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // advance one edge, sample 1 ns later, then idle all strobes
    task automatic step();
        @(posedge clk);
        #1;
        io_wr = 0; alu_we = 0; irq_enter = 0; irq_return = 0;
        bst_req = 0; sp_push = 0; sp_pop = 0;
    endtask

    task automatic io_write(input logic [5:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1;
        step();
    endtask

    function automatic int sreg_exp(input logic [7:0] w);
        logic [7:0] r = w;
        r[4] = w[3] ^ w[2];
        return int'(r);
    endfunction

    initial begin
        #1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset values
        io_addr = 6'h3F; #1 chk("R1 status", io_rdata, 0);
        io_addr = 6'h3E; #1 chk("R1 sp hi", io_rdata, 0);
        io_addr = 6'h3D; #1 chk("R1 sp lo", io_rdata, 0);
        chk("R1 gie", gie, 0);
        chk("R1 t", t_bit, 0);
        chk("R1 sp", sp_value, 0);

        // R2 R3 full sweep of written status values
        for (int v = 0; v < 256; v++) begin
            io_write(6'h3F, 8'(v));
            chk("R2 R3 status readback", io_rdata, sreg_exp(8'(v)));
            chk("R2 gie", gie, (v >> 7) & 1);
        end

        // R3 R6 all N,V combinations through the ALU path
        io_write(6'h3F, 8'h00);
        for (int nv = 0; nv < 4; nv++) begin
            alu_we = 5'b01100;
            alu_val = {1'b0, 1'(nv >> 1), 1'(nv & 1), 2'b00};
            step();
            chk("R3 S from ALU N,V", status_word,
                (((nv >> 1) ^ (nv & 1)) << 4) | ((nv >> 1) << 3) | ((nv & 1) << 2));
        end
        // R6 masked update: only C changes
        io_write(6'h3F, 8'hEF);
        alu_we = 5'b00001; alu_val = 5'b11110;
        step();
        chk("R6 mask only C", status_word, 8'hEE);
        // R6 io write beats ALU
        alu_we = 5'b11111; alu_val = 5'b11111;
        io_write(6'h3F, 8'h00);
        chk("R6 io priority", status_word, 8'h00);

        // R4 R5 R11 interrupt entry and return
        io_write(6'h3F, 8'hAB);
        chk("R2 store 0xAB", status_word, 8'hBB);
        irq_enter = 1; step();
        chk("R4 R11 enter clears I only", status_word, 8'h3B);
        chk("R4 gie low", gie, 0);
        irq_return = 1; step();
        chk("R5 R11 return sets I only", status_word, 8'hBB);
        irq_enter = 1; irq_return = 1; step();
        chk("R4 enter beats return", status_word, 8'h3B);
        irq_enter = 1;
        io_write(6'h3F, 8'hFF);
        chk("R4 enter beats io write", status_word, 8'h6F);

        // R7 bit store, every selector, both polarities
        for (int s = 0; s < 8; s++) begin
            for (int p = 0; p < 2; p++) begin
                bst_sel = 3'(s);
                bst_src = p ? ~(8'd1 << s) : (8'd1 << s);
                bst_req = 1; step();
                chk("R7 bst into T", t_bit, p ? 0 : 1);
                chk("R7 T in status bit 6", (status_word >> 6) & 1, p ? 0 : 1);
            end
        end
        bst_sel = 0; bst_src = 8'h01; bst_req = 1;
        io_write(6'h3F, 8'h00);
        chk("R7 io write beats bst", t_bit, 0);

        // R7 bit load, every selector, both T values
        for (int t = 0; t < 2; t++) begin
            io_write(6'h3F, t ? 8'h40 : 8'h00);
            for (int s = 0; s < 8; s++) begin
                bld_dst = 8'hA5; bld_sel = 3'(s); #1;
                chk("R7 bld result", bld_result,
                    t ? (8'hA5 | (8'd1 << s)) : (8'hA5 & ~(8'd1 << s)));
            end
        end

        // R8 high-byte sweep, unused bits read 0
        for (int v = 0; v < 256; v++) begin
            io_write(6'h3E, 8'(v));
            chk("R8 sp hi masked", io_rdata, v & (SP_MASK >> 8));
        end
        io_write(6'h3D, 8'h5A);
        chk("R8 sp lo", io_rdata, 8'h5A);
        chk("R8 sp value", sp_value, (((255 & (SP_MASK >> 8)) << 8) | 8'h5A));

        // R9 push / pop with wrap
        io_write(6'h3E, 8'h00);
        io_write(6'h3D, 8'h00);
        sp_push = 1; #1;
        chk("R9 push addr", stack_addr, 0);
        step();
        chk("R9 push wraps down", sp_value, SP_MASK);
        sp_pop = 1; #1;
        chk("R9 pop addr wraps", stack_addr, 0);
        step();
        chk("R9 pop wraps up", sp_value, 0);
        io_write(6'h3E, 8'h01);
        io_write(6'h3D, 8'h23);
        for (int k = 1; k <= 4; k++) begin
            sp_push = 1; step();
            chk("R9 push steps", sp_value, 16'h123 - k);
        end
        sp_pop = 1; #1;
        chk("R9 pop addr", stack_addr, 16'h120);
        step();
        chk("R9 pop step", sp_value, 16'h120);

        // R10 priorities
        sp_push = 1; sp_pop = 1; step();
        chk("R10 push+pop hold", sp_value, 16'h120);
        sp_push = 1;
        io_write(6'h3D, 8'h77);
        chk("R10 io beats push", sp_value, 16'h177);
        sp_pop = 1;
        io_write(6'h3E, 8'hFE);
        chk("R10 io hi beats pop", sp_value, ((8'hFE & (SP_MASK >> 8)) << 8) | 8'h77);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule